// File: doc/BRIEF.md
# Tape Label and Speed Detector

This block watches the sliced envelope bit recovered from the auxiliary track while a tape deck winds fast in search mode. It raises a label flag when the envelope sits HIGH for a sustained stretch, and a virgin-tape flag when it sits LOW for a sustained stretch. Both flags use a persistence count of auxiliary block periods, marked by a one-cycle block tick, so short dropouts or bursts do not toggle them.

The block also times every complete label region, from the envelope rise to its fall, on a prescaled clock. It reports the result as a speed word: an invalid flag, a 5-bit count and a 2-bit range exponent. Tape speed is proportional to 2^range / count. The range steps automatically to keep the count in a useful working band. Outside search mode every envelope-derived output is held LOW and the speed word is invalid.

Top module: `tape_search_detector`

## Requirements
- R1: With `search_en` LOW, `env_out`, `label_flag` and `virgin_flag` are 0 one cycle later. The speed word then reads `spd_invalid`=1, `spd_count`=0 and `spd_range`=0, whatever `env_in` and `blk_tick` do.
- R2: In search mode, `env_out` equals `env_in` delayed by one clock cycle.
- R3: `label_flag` becomes 1 on the 8th `blk_tick` during which `env_in` has stayed HIGH since its last change, and not earlier. A tick in the same cycle as an envelope change is not counted.
- R4: `virgin_flag` becomes 1 on the 8th `blk_tick` during which `env_in` has stayed LOW since its last change, and not earlier.
- R5: A flag clears only when the opposite level has persisted for 8 ticks, at which point the other flag sets. A shorter run of the opposite level restarts the run and leaves both flags unchanged. The two flags are never 1 together.
- R6: A label region whose `env_in` stays HIGH for H clock cycles, beginning with a rising edge seen in search mode, measures m = floor((H-1)/P) with P = BASE_DIV >> range (BASE_DIV default 64). m saturates at 31. The speed word updates in the cycle after the fall.
- R7: When 4 <= m <= 24, the word reports `spd_count`=m, `spd_invalid`=0 and `spd_range` unchanged. The same holds when m > 24 at range 0.
- R8: When m < 4 and range < 3, the range goes up by one and `spd_invalid` becomes 1.
- R9: When m > 24 and range > 0, the range goes down by one and `spd_invalid` becomes 1.
- R10: After search mode begins, `spd_invalid` stays 1 until a complete label has been timed. A label already HIGH when search begins is not timed.
- R11: At range 3, any m below 4, including 0, is reported as valid. A count of 0 means the speed is above the top of that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_en | input | 1 | Search mode active |
| blk_tick | input | 1 | One-cycle pulse per nominal auxiliary block period |
| env_in | input | 1 | Sliced envelope bit of the auxiliary track |
| env_out | output | 1 | Gated, registered envelope |
| label_flag | output | 1 | Sustained label region detected |
| virgin_flag | output | 1 | Sustained blank tape detected |
| spd_invalid | output | 1 | Speed word is meaningless when 1 |
| spd_count | output | 5 | Label duration in prescaled units |
| spd_range | output | 2 | Range exponent of the speed word |

## Verification
A wrong run counter in the persistence filter shows up as a flag edge one or more ticks early or late, within 8 block ticks of the envelope change. Run lengths of 7 and 8 ticks are probed to catch this. A wrong prescale or label timer shows up as a count that is off by one or more units in the cycle after the label falls. A stuck range shows up as a missing invalid flag and an unchanged range at that same point. Chains of short labels drive the range from 0 to 3, and long labels drive it back down, so every step direction and both range limits are visible within a few thousand cycles.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  localparam int CNT_W = 5;
  localparam int RNG_W = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [RNG_W-1:0] RNG_MAX = {RNG_W{1'b1}};
endpackage

// File: rtl/tsd_persist.sv
module tsd_persist #(
  parameter int PERSIST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic search_en,
  input  logic blk_tick,
  input  logic env_in,
  output logic env_o,
  output logic label_o,
  output logic virgin_o
);
  localparam int RW = $clog2(PERSIST + 1);
  localparam logic [RW-1:0] RUN_FULL = RW'(PERSIST);
  localparam logic [RW-1:0] RUN_LAST = RW'(PERSIST - 1);

  logic          env_q, env_nx;
  logic [RW-1:0] run_q, run_nx;
  logic          lab_q, lab_nx;
  logic          vir_q, vir_nx;
  logic          eo_q, eo_nx;

  always_comb begin
    env_nx = env_in;
    run_nx = run_q;
    lab_nx = lab_q;
    vir_nx = vir_q;
    eo_nx  = search_en & env_in;
    if (!search_en) begin
      run_nx = '0;
      lab_nx = 1'b0;
      vir_nx = 1'b0;
    end else if (env_in != env_q) begin
      run_nx = '0;
    end else if (blk_tick && (run_q != RUN_FULL)) begin
      run_nx = run_q + 1'b1;
      if (run_q == RUN_LAST) begin
        lab_nx = env_in;
        vir_nx = ~env_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env_q <= 1'b0;
      run_q <= '0;
      lab_q <= 1'b0;
      vir_q <= 1'b0;
      eo_q  <= 1'b0;
    end else begin
      env_q <= env_nx;
      run_q <= run_nx;
      lab_q <= lab_nx;
      vir_q <= vir_nx;
      eo_q  <= eo_nx;
    end
  end

  assign env_o    = eo_q;
  assign label_o  = lab_q;
  assign virgin_o = vir_q;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> (!lab_q && !vir_q && !eo_q)); // R1
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lab_q && vir_q)); // R5
  AST_LABEL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lab_q) |-> env_q); // R3
  AST_VIRGIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vir_q) |-> !env_q); // R4
endmodule

// File: rtl/tsd_label_timer.sv
module tsd_label_timer
  import tsd_pkg::*;
#(
  parameter int BASE_DIV = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_en,
  input  logic             env_in,
  input  logic [RNG_W-1:0] rng,
  output logic             done_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam int DW = $clog2(BASE_DIV);

  logic             prev_q;
  logic             in_q, in_nx;
  logic [DW-1:0]    div_q, div_nx;
  logic [CNT_W-1:0] m_q, m_nx;
  logic [DW-1:0]    per_last;

  always_comb per_last = DW'((BASE_DIV >> rng) - 1);

  always_comb begin
    in_nx  = in_q;
    div_nx = div_q;
    m_nx   = m_q;
    if (!search_en) begin
      in_nx  = 1'b0;
      div_nx = '0;
      m_nx   = '0;
    end else if (env_in && !prev_q) begin
      in_nx  = 1'b1;
      div_nx = '0;
      m_nx   = '0;
    end else if (in_q && env_in) begin
      if (div_q == per_last) begin
        div_nx = '0;
        if (m_q != CNT_MAX) m_nx = m_q + 1'b1;
      end else begin
        div_nx = div_q + 1'b1;
      end
    end else if (in_q) begin
      in_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      in_q   <= 1'b0;
      div_q  <= '0;
      m_q    <= '0;
    end else begin
      prev_q <= env_in;
      in_q   <= in_nx;
      div_q  <= div_nx;
      m_q    <= m_nx;
    end
  end

  assign done_o = search_en & in_q & ~env_in;
  assign meas_o = m_q;

  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && $past(in_q)) |-> (m_q >= $past(m_q))); // R6
  AST_OFF_NO_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> !in_q); // R10
endmodule

// File: rtl/tsd_range_ctl.sv
module tsd_range_ctl
  import tsd_pkg::*;
#(
  parameter int UP_BELOW   = 4,
  parameter int DOWN_ABOVE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_en,
  input  logic             done_i,
  input  logic [CNT_W-1:0] meas_i,
  output logic             inv_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [RNG_W-1:0] rng_o
);
  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(UP_BELOW);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(DOWN_ABOVE);

  logic             inv_q, inv_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [RNG_W-1:0] rng_q, rng_nx;

  always_comb begin
    inv_nx = inv_q;
    cnt_nx = cnt_q;
    rng_nx = rng_q;
    if (!search_en) begin
      inv_nx = 1'b1;
      cnt_nx = '0;
      rng_nx = '0;
    end else if (done_i) begin
      cnt_nx = meas_i;
      if ((meas_i < LO_LIM) && (rng_q != RNG_MAX)) begin
        rng_nx = rng_q + 1'b1;
        inv_nx = 1'b1;
      end else if ((meas_i > HI_LIM) && (rng_q != '0)) begin
        rng_nx = rng_q - 1'b1;
        inv_nx = 1'b1;
      end else begin
        inv_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= 1'b1;
      cnt_q <= '0;
      rng_q <= '0;
    end else begin
      inv_q <= inv_nx;
      cnt_q <= cnt_nx;
      rng_q <= rng_nx;
    end
  end

  assign inv_o = inv_q;
  assign cnt_o = cnt_q;
  assign rng_o = rng_q;

  AST_RANGE_MOVE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rng_q != $past(rng_q)) |-> inv_q); // R8
  AST_RANGE_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (search_en && $past(search_en)) |->
      ((rng_q == $past(rng_q)) || (rng_q == $past(rng_q) + 2'd1) ||
       (rng_q + 2'd1 == $past(rng_q)))); // R9
  AST_OFF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> (inv_q && (rng_q == '0))); // R1
endmodule

// File: rtl/tape_search_detector.sv
module tape_search_detector
  import tsd_pkg::*;
#(
  parameter int PERSIST    = 8,
  parameter int BASE_DIV   = 64,
  parameter int UP_BELOW   = 4,
  parameter int DOWN_ABOVE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             search_en,
  input  logic             blk_tick,
  input  logic             env_in,
  output logic             env_out,
  output logic             label_flag,
  output logic             virgin_flag,
  output logic             spd_invalid,
  output logic [CNT_W-1:0] spd_count,
  output logic [RNG_W-1:0] spd_range
);
  logic             rst_s1_q, rst_s2_q;
  logic             done_w;
  logic [CNT_W-1:0] meas_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  tsd_persist #(.PERSIST(PERSIST)) u_persist (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .search_en (search_en),
    .blk_tick  (blk_tick),
    .env_in    (env_in),
    .env_o     (env_out),
    .label_o   (label_flag),
    .virgin_o  (virgin_flag)
  );

  tsd_label_timer #(.BASE_DIV(BASE_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .search_en (search_en),
    .env_in    (env_in),
    .rng       (spd_range),
    .done_o    (done_w),
    .meas_o    (meas_w)
  );

  tsd_range_ctl #(.UP_BELOW(UP_BELOW), .DOWN_ABOVE(DOWN_ABOVE)) u_range (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .search_en (search_en),
    .done_i    (done_w),
    .meas_i    (meas_w),
    .inv_o     (spd_invalid),
    .cnt_o     (spd_count),
    .rng_o     (spd_range)
  );
endmodule

// File: tb/tape_search_detector_bench.sv
module tape_search_detector_bench;
  logic       clk;
  logic       rst_n;
  logic       search_en;
  logic       blk_tick;
  logic       env_in;
  logic       env_out;
  logic       label_flag;
  logic       virgin_flag;
  logic       spd_invalid;
  logic [4:0] spd_count;
  logic [1:0] spd_range;

  int checks;
  int failures;
  bit done_flag;

  tape_search_detector u_tape_search_detector (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .blk_tick(blk_tick),
    .env_in(env_in), .env_out(env_out), .label_flag(label_flag),
    .virgin_flag(virgin_flag), .spd_invalid(spd_invalid),
    .spd_count(spd_count), .spd_range(spd_range)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_speed(input string req, input int inv, input int cnt, input int rng);
    check({req, " invalid"}, spd_invalid, inv);
    check({req, " count"}, spd_count, cnt);
    check({req, " range"}, spd_range, rng);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) blk_tick = 1'b1;
      @(negedge clk) blk_tick = 1'b0;
    end
  endtask

  task automatic label_pulse(input int h);
    @(negedge clk) env_in = 1'b1;
    repeat (h) @(negedge clk);
    env_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset env_out", env_out, 0);
    check("R1 reset label", label_flag, 0);
    check("R1 reset virgin", virgin_flag, 0);
    check_speed("R10 reset", 1, 0, 0);
  endtask

  task automatic t_gated_off;
    @(negedge clk) env_in = 1'b1;
    ticks(10);
    check("R1 off env_out", env_out, 0);
    check("R1 off label", label_flag, 0);
  endtask

  task automatic t_label_set;
    @(negedge clk) search_en = 1'b1;
    @(negedge clk);
    check("R2 env_out follows high", env_out, 1);
    ticks(7);
    check("R3 label not after 7", label_flag, 0);
    ticks(1);
    check("R3 label after 8", label_flag, 1);
    check("R3 virgin low", virgin_flag, 0);
  endtask

  task automatic t_glitch_and_virgin;
    @(negedge clk) env_in = 1'b0;
    @(negedge clk);
    check("R2 env_out follows low", env_out, 0);
    check("R10 partial label untimed", spd_invalid, 1);
    ticks(3);
    env_in = 1'b1;
    ticks(2);
    env_in = 1'b0;
    check("R5 short low run keeps label", label_flag, 1);
    ticks(7);
    check("R5 label held after 7 low", label_flag, 1);
    check("R5 virgin not yet", virgin_flag, 0);
    ticks(1);
    check("R5 label cleared", label_flag, 0);
    check("R4 virgin set after 8", virgin_flag, 1);
    check_speed("R8 short label range up", 1, 0, 1);
  endtask

  task automatic t_measure;
    label_pulse(10 * 32 + 16);
    check_speed("R6 R7 count at range 1", 0, 10, 1);
    label_pulse(40 * 32);
    check_speed("R9 saturated range down", 1, 31, 0);
    label_pulse(24 * 64 + 32);
    check_speed("R7 upper boundary", 0, 24, 0);
    label_pulse(4 * 64 + 32);
    check_speed("R7 lower boundary", 0, 4, 0);
    label_pulse(30 * 64 + 32);
    check_speed("R7 long at bottom range", 0, 30, 0);
  endtask

  task automatic t_climb;
    label_pulse(16);
    check_speed("R8 up to 1", 1, 0, 1);
    label_pulse(8);
    check_speed("R8 up to 2", 1, 0, 2);
    label_pulse(4);
    check_speed("R8 up to 3", 1, 0, 3);
    label_pulse(4);
    check_speed("R11 zero at top", 0, 0, 3);
    label_pulse(2 * 8 + 4);
    check_speed("R11 small at top", 0, 2, 3);
  endtask

  task automatic t_exit_reenter;
    @(negedge clk) search_en = 1'b0;
    @(negedge clk);
    check("R1 exit virgin", virgin_flag, 0);
    check_speed("R1 exit speed", 1, 0, 0);
    @(negedge clk) search_en = 1'b1;
    ticks(7);
    check("R4 virgin not after 7", virgin_flag, 0);
    ticks(1);
    check("R4 virgin after 8", virgin_flag, 1);
    check("R10 invalid after reentry", spd_invalid, 1);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done_flag = 1'b0;
    rst_n = 1'b0;
    search_en = 1'b0;
    blk_tick = 1'b0;
    env_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_gated_off();
    t_label_set();
    t_glitch_and_virgin();
    t_measure();
    t_climb();
    t_exit_reenter();
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule